// File: doc/BRIEF.md
# PHY event interrupt controller

This block gathers status conditions from a transceiver's management space and turns them into a single active-low interrupt line. Each condition has a sticky flag in a flag register. A flag is set by one particular edge of its status input. It is cleared by the condition going away, by reads of particular management addresses, or by link events, and the rules differ from flag to flag. A mask register chooses which flags may pull the interrupt line low.

Software reaches both registers through a small register port: one address bus shared by a write strobe and a read strobe. Reads of other management addresses also appear on this port. The block does not hold data for those addresses, but it watches them because several flags are cleared when those registers are read. Status inputs may arrive from other clock domains. They pass through a synchronizer before edge detection.

Top module: `phy_irq_ctrl`

## Requirements
- R1: `irq_n` is low when at least one flag bit and its mask bit are both 1, and high otherwise.
- R2: After reset the mask and the flags are all zero and `irq_n` is high.
- R3: The mask is written and read at address 30. Only bits 10:4 and 2:1 are writable, and every other bit reads 0. Writes to address 29 have no effect on the flags.
- R4: A change on a status input reaches the flag register on the third rising clock edge after the input is driven (two synchronizer stages plus one edge stage).
- R5: A read of address 29 returns the flags as they were before that read. The read then clears bits 7, 6, 5, 4, 2 and 1, and leaves bits 10, 9 and 8 unchanged.
- R6: Bit 7 (`energy_on`), bit 6 (`an_done`) and bit 5 (`rem_fault`) are set by a rising edge and cleared by a falling edge of their input.
- R7: Bit 4 is set by a falling edge of `link_up`. Bits 5 and 4 are cleared by a read of address 1.
- R8: Bits 2 (`pd_fault`) and 1 (`page_rx`) are set by a rising edge. They are cleared by a falling edge of their input, a read of address 6, a rising edge of `an_restart`, or a falling edge of `link_up`.
- R9: Bits 10 (`tx_ovf`) and 9 (`tx_unf`) are set by a rising edge and cleared by a falling edge. Bit 8 is set by a rising edge of `idle_ovf` and is cleared only by a read of address 10.
- R10: When a set event and a clear event for the same flag fall in the same cycle, the flag ends up set.
- R11: Reads of any address other than 29 and 30 return 0 on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd_en | input | 1 | Read strobe, also raised for reads of other addresses |
| reg_rdata | output | 16 | Read data for the addressed register |
| energy_on | input | 1 | Energy present status |
| an_done | input | 1 | Auto-negotiation complete status |
| rem_fault | input | 1 | Remote fault status |
| link_up | input | 1 | Link status |
| pd_fault | input | 1 | Parallel detection fault status |
| page_rx | input | 1 | Page received status |
| tx_ovf | input | 1 | Transmit buffer overflow condition |
| tx_unf | input | 1 | Transmit buffer underflow condition |
| idle_ovf | input | 1 | Idle error counter overflow |
| an_restart | input | 1 | Auto-negotiation restart indication |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is a collision: a synchronized set edge has to land at the edge stage in exactly the cycle when a clearing read or link event is captured. The bench reaches it in two ways. A directed sequence drives a read of address 29 on the third edge after a status rise. Long random runs, which mix toggling status lines with reads of addresses 1, 6, 10, 29 and 30, hit many more such alignments. A cycle-accurate bench model predicts every read value and the state of `irq_n` on every cycle.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int REG_W  = 16;
    localparam int N_STAT = 10;

    // status vector positions
    localparam int S_ENERGY  = 0;
    localparam int S_ANDONE  = 1;
    localparam int S_RFAULT  = 2;
    localparam int S_LINK    = 3;
    localparam int S_PDF     = 4;
    localparam int S_PAGE    = 5;
    localparam int S_TXOVF   = 6;
    localparam int S_TXUNF   = 7;
    localparam int S_IDLE    = 8;
    localparam int S_RESTART = 9;

    // flag register bit positions (software decodes these)
    localparam int F_TXOVF  = 10;
    localparam int F_TXUNF  = 9;
    localparam int F_IDLE   = 8;
    localparam int F_ENERGY = 7;
    localparam int F_ANDONE = 6;
    localparam int F_RFAULT = 5;
    localparam int F_LDOWN  = 4;
    localparam int F_PDF    = 2;
    localparam int F_PAGE   = 1;

    localparam logic [REG_W-1:0] RW_BITS = 16'h07F6;
    localparam logic [REG_W-1:0] CLR_ON_FLAG_READ = 16'h00F6;

    typedef struct packed {
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] flags;
    } irq_regs_t;

endpackage

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            if (i == 0) stg_d[i] = d;
            else        stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/phy_irq_edge.sv
module phy_irq_edge #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
        fall   = ~lvl & prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    // R4: an edge pulse lasts a single cycle
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phy_irq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter int MASK_ADDR   = 30,
    parameter int FLAG_ADDR   = 29,
    parameter int STAT_ADDR   = 1,
    parameter int ANEXP_ADDR  = 6,
    parameter int IDLE_ADDR   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd_en,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              energy_on,
    input  logic              an_done,
    input  logic              rem_fault,
    input  logic              link_up,
    input  logic              pd_fault,
    input  logic              page_rx,
    input  logic              tx_ovf,
    input  logic              tx_unf,
    input  logic              idle_ovf,
    input  logic              an_restart,
    output logic              irq_n
);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(MASK_ADDR);
    localparam logic [ADDR_W-1:0] A_FLAG  = ADDR_W'(FLAG_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_ANEXP = ADDR_W'(ANEXP_ADDR);
    localparam logic [ADDR_W-1:0] A_IDLE  = ADDR_W'(IDLE_ADDR);

    logic [N_STAT-1:0] stat_raw, stat_sync, rise, fall;
    irq_regs_t         st_d, st_q;
    logic [REG_W-1:0]  set_ev, clr_ev;
    logic              rd_flag, rd_stat, rd_anexp, rd_idle, wr_mask, link_lost;

    always_comb begin
        stat_raw            = '0;
        stat_raw[S_ENERGY]  = energy_on;
        stat_raw[S_ANDONE]  = an_done;
        stat_raw[S_RFAULT]  = rem_fault;
        stat_raw[S_LINK]    = link_up;
        stat_raw[S_PDF]     = pd_fault;
        stat_raw[S_PAGE]    = page_rx;
        stat_raw[S_TXOVF]   = tx_ovf;
        stat_raw[S_TXUNF]   = tx_unf;
        stat_raw[S_IDLE]    = idle_ovf;
        stat_raw[S_RESTART] = an_restart;
    end

    phy_irq_sync #(.W(N_STAT), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(stat_raw), .q(stat_sync)
    );

    phy_irq_edge #(.W(N_STAT)) i_edge (
        .clk(clk), .rst_n(rst_n), .lvl(stat_sync), .rise(rise), .fall(fall)
    );

    always_comb begin
        rd_flag   = reg_rd_en && (reg_addr == A_FLAG);
        rd_stat   = reg_rd_en && (reg_addr == A_STAT);
        rd_anexp  = reg_rd_en && (reg_addr == A_ANEXP);
        rd_idle   = reg_rd_en && (reg_addr == A_IDLE);
        wr_mask   = reg_wr_en && (reg_addr == A_MASK);
        link_lost = fall[S_LINK];

        set_ev           = '0;
        set_ev[F_TXOVF]  = rise[S_TXOVF];
        set_ev[F_TXUNF]  = rise[S_TXUNF];
        set_ev[F_IDLE]   = rise[S_IDLE];
        set_ev[F_ENERGY] = rise[S_ENERGY];
        set_ev[F_ANDONE] = rise[S_ANDONE];
        set_ev[F_RFAULT] = rise[S_RFAULT];
        set_ev[F_LDOWN]  = fall[S_LINK];
        set_ev[F_PDF]    = rise[S_PDF];
        set_ev[F_PAGE]   = rise[S_PAGE];

        clr_ev           = rd_flag ? CLR_ON_FLAG_READ : '0;
        clr_ev[F_TXOVF]  = fall[S_TXOVF];
        clr_ev[F_TXUNF]  = fall[S_TXUNF];
        clr_ev[F_IDLE]   = rd_idle;
        clr_ev[F_ENERGY] = clr_ev[F_ENERGY] | fall[S_ENERGY];
        clr_ev[F_ANDONE] = clr_ev[F_ANDONE] | fall[S_ANDONE];
        clr_ev[F_RFAULT] = clr_ev[F_RFAULT] | fall[S_RFAULT] | rd_stat;
        clr_ev[F_LDOWN]  = clr_ev[F_LDOWN] | rd_stat;
        clr_ev[F_PDF]    = clr_ev[F_PDF] | fall[S_PDF] | rd_anexp
                         | rise[S_RESTART] | link_lost;
        clr_ev[F_PAGE]   = clr_ev[F_PAGE] | fall[S_PAGE] | rd_anexp
                         | rise[S_RESTART] | link_lost;

        st_d = st_q;
        if (wr_mask) st_d.mask = reg_wdata & RW_BITS;
        // a set in the same cycle as a clear wins
        st_d.flags = (set_ev | (st_q.flags & ~clr_ev)) & RW_BITS;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (reg_addr == A_MASK)      reg_rdata = st_q.mask;
        else if (reg_addr == A_FLAG) reg_rdata = st_q.flags;
        else                         reg_rdata = '0;
        irq_n = ~|(st_q.mask & st_q.flags);
    end

    p_rst_clear_r2: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q == '0));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(st_q.mask));

    p_flag_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == A_FLAG && set_ev == '0)
        |=> ((st_q.flags & ~$past(st_q.flags)) == '0));

    p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_flag && (set_ev & CLR_ON_FLAG_READ) == '0)
        |=> ((st_q.flags & CLR_ON_FLAG_READ) == '0));

    p_idle_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flags[F_IDLE] && !rd_idle) |=> st_q.flags[F_IDLE]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev != '0) |=> ((st_q.flags & $past(set_ev)) == $past(set_ev)));

    p_quiet_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mask && reg_wdata == '0) |=> irq_n);
endmodule

// File: tb/test_phy_irq_ctrl.sv
module test_phy_irq_ctrl;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd_en = 1'b0;
    logic [15:0] reg_rdata;
    logic        energy_on = 0, an_done = 0, rem_fault = 0, link_up = 0, pd_fault = 0;
    logic        page_rx = 0, tx_ovf = 0, tx_unf = 0, idle_ovf = 0, an_restart = 0;
    logic        irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [15:0] last_rd;

    // bench model: bit order energy, an, rfault, link, pd, page, ovf, unf, idle, restart
    logic [9:0]  m_s1 = '0, m_s2 = '0, m_pv = '0;
    logic [15:0] m_mask = '0, m_flags = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_irq_ctrl i_phy_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en), .reg_rdata(reg_rdata),
        .energy_on(energy_on), .an_done(an_done), .rem_fault(rem_fault),
        .link_up(link_up), .pd_fault(pd_fault), .page_rx(page_rx),
        .tx_ovf(tx_ovf), .tx_unf(tx_unf), .idle_ovf(idle_ovf),
        .an_restart(an_restart), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [9:0] cur_inputs();
        return {an_restart, idle_ovf, tx_unf, tx_ovf, page_rx, pd_fault,
                link_up, rem_fault, an_done, energy_on};
    endfunction

    function automatic logic [15:0] next_flags(input logic [15:0] f, input logic [9:0] r,
                                               input logic [9:0] fl, input logic rd,
                                               input logic [4:0] a);
        logic [15:0] s = '0, c = '0;
        logic r29 = rd && a == 5'd29;
        logic r1  = rd && a == 5'd1;
        logic r6  = rd && a == 5'd6;
        logic r10 = rd && a == 5'd10;
        logic pdclr = fl[4] | r6 | r29 | r[9] | fl[3];
        logic pgclr = fl[5] | r6 | r29 | r[9] | fl[3];
        s[10] = r[6]; c[10] = fl[6];
        s[9]  = r[7]; c[9]  = fl[7];
        s[8]  = r[8]; c[8]  = r10;
        s[7]  = r[0]; c[7]  = fl[0] | r29;
        s[6]  = r[1]; c[6]  = fl[1] | r29;
        s[5]  = r[2]; c[5]  = fl[2] | r1 | r29;
        s[4]  = fl[3]; c[4] = r1 | r29;
        s[2]  = r[4]; c[2]  = pdclr;
        s[1]  = r[5]; c[1]  = pgclr;
        return (s | (f & ~c)) & 16'h07F6;
    endfunction

    // one clock: check read data, advance model, check irq after the edge
    task automatic tick();
        logic [9:0] r, fl;
        #1;
        if (reg_rd_en) begin
            last_rd = reg_rdata;
            if (reg_addr == 5'd29)      check("R5 flag read", reg_rdata, m_flags);
            else if (reg_addr == 5'd30) check("R3 mask read", reg_rdata, m_mask);
            else                        check("R11 other read", reg_rdata, 16'h0);
        end
        r  = m_s2 & ~m_pv;
        fl = ~m_s2 & m_pv;
        m_flags = next_flags(m_flags, r, fl, reg_rd_en, reg_addr);
        if (reg_wr_en && reg_addr == 5'd30) m_mask = reg_wdata & 16'h07F6;
        m_pv = m_s2; m_s2 = m_s1; m_s1 = cur_inputs();
        @(posedge clk);
        @(negedge clk);
        check("R1 irq", {15'd0, irq_n}, {15'd0, ~|(m_mask & m_flags)});
        reg_rd_en = 1'b0;
        reg_wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic rd(input logic [4:0] a);
        reg_addr = a; reg_rd_en = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        tick();
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: reset state
        check("R2 irq after reset", {15'd0, irq_n}, 16'h0001);
        rd(5'd30); check("R2 mask zero", last_rd, 16'h0);
        rd(5'd29); check("R2 flags zero", last_rd, 16'h0);

        // R3: writable bits, flag register not writable
        wr(5'd30, 16'hFFFF);
        rd(5'd30); check("R3 mask bits", last_rd, 16'h07F6);
        wr(5'd29, 16'hFFFF);
        rd(5'd29); check("R3 flag write ignored", last_rd, 16'h0);
        rd(5'd5);  check("R11 unmapped read", last_rd, 16'h0);

        // R4: three edges to the flag
        energy_on = 1'b1;
        ticks(2);
        check("R4 not yet", {15'd0, irq_n}, 16'h0001);
        tick();
        check("R4 flag after third edge", {15'd0, irq_n}, 16'h0000);

        // R6: falling edge clears
        energy_on = 1'b0;
        ticks(3);
        check("R6 energy fall clears", {15'd0, irq_n}, 16'h0001);
        an_done = 1'b1; ticks(4);
        rd(5'd29); check("R6 an_done set", last_rd, 16'h0040);
        an_done = 1'b0; ticks(4);
        rd(5'd29); check("R5 read cleared", last_rd, 16'h0000);

        // R10: rise at edge stage with a read of 29 in the same cycle
        energy_on = 1'b1;
        ticks(2);
        rd(5'd29); check("R10 pre-read value", last_rd, 16'h0000);
        rd(5'd29); check("R10 set wins over read", last_rd, 16'h0080);

        // R7: link down flag and clear by read of address 1
        link_up = 1'b1; ticks(4);
        link_up = 1'b0; ticks(4);
        rd(5'd29); check("R7 link down set", last_rd & 16'h0010, 16'h0010);
        link_up = 1'b1; ticks(4);
        link_up = 1'b0; ticks(4);
        rd(5'd1);
        rd(5'd29); check("R7 cleared by address 1", last_rd & 16'h0010, 16'h0000);

        // R8: restart and address 6 clear bits 2 and 1
        pd_fault = 1'b1; page_rx = 1'b1; ticks(4);
        an_restart = 1'b1; ticks(4);
        rd(5'd29); check("R8 restart clears", last_rd & 16'h0006, 16'h0000);
        pd_fault = 1'b0; page_rx = 1'b0; an_restart = 1'b0; ticks(4);
        pd_fault = 1'b1; page_rx = 1'b1; ticks(4);
        rd(5'd6);
        rd(5'd29); check("R8 address 6 clears", last_rd & 16'h0006, 16'h0000);

        // R9: sticky idle overflow, level-following buffer flags
        idle_ovf = 1'b1; tx_ovf = 1'b1; ticks(4);
        idle_ovf = 1'b0; ticks(4);
        rd(5'd29); check("R9 idle set", last_rd & 16'h0700, 16'h0500);
        rd(5'd29); check("R9 idle survives 29 read", last_rd & 16'h0100, 16'h0100);
        tx_ovf = 1'b0; ticks(4);
        rd(5'd10);
        rd(5'd29); check("R9 cleared by 10 and fall", last_rd & 16'h0700, 16'h0000);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            if ($urandom_range(0, 9) == 0) energy_on  = ~energy_on;
            if ($urandom_range(0, 9) == 0) an_done    = ~an_done;
            if ($urandom_range(0, 9) == 0) rem_fault  = ~rem_fault;
            if ($urandom_range(0, 14) == 0) link_up   = ~link_up;
            if ($urandom_range(0, 9) == 0) pd_fault   = ~pd_fault;
            if ($urandom_range(0, 9) == 0) page_rx    = ~page_rx;
            if ($urandom_range(0, 9) == 0) tx_ovf     = ~tx_ovf;
            if ($urandom_range(0, 9) == 0) tx_unf     = ~tx_unf;
            if ($urandom_range(0, 9) == 0) idle_ovf   = ~idle_ovf;
            if ($urandom_range(0, 19) == 0) an_restart = ~an_restart;
            case ($urandom_range(0, 11))
                0: begin reg_addr = 5'd29; reg_rd_en = 1'b1; end
                1: begin reg_addr = 5'd1;  reg_rd_en = 1'b1; end
                2: begin reg_addr = 5'd6;  reg_rd_en = 1'b1; end
                3: begin reg_addr = 5'd10; reg_rd_en = 1'b1; end
                4: begin reg_addr = 5'd30; reg_rd_en = 1'b1; end
                5: if ($urandom_range(0, 7) == 0) begin
                       reg_addr = 5'd30; reg_wr_en = 1'b1;
                       reg_wdata = 16'($urandom());
                   end
                6: begin reg_addr = 5'($urandom()); reg_rd_en = 1'b1; end
                default: ;
            endcase
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule